// File: doc/BRIEF.md
# Guarded Memory Access Issue Gate

This block sits between a load/store unit and the system bus and decides when an access that missed in the cache may place its request on the bus. An access to an unguarded page is sent out at once, even while older instructions are still unresolved. An access to a guarded page is held until every older instruction is known to finish without an exception. Until then it may be speculative, because it follows an unresolved branch, or faultable, because an older instruction might still trap.

Before the bus acknowledges the address, a flush cancels the access and withdraws its request. The flush may come from an exception, a mispredicted branch or a pending asynchronous interrupt. Once the address is acknowledged, the access is committed and runs to the end regardless of flushes or interrupts.

A read retires after its data has returned. A write retires as soon as its address is accepted. The gate handles one access at a time and shows through a ready output when it can take a new one.

Top module: `guard_issue_gate`

## Requirements
- R1: An access presented with `acc_hit` high is not taken: `bus_req` stays low and `acc_ready` stays high.
- R2: An unguarded miss accepted while idle raises `bus_req` in the following cycle, whatever the value of `older_safe`.
- R3: A guarded miss accepted while `older_safe` is low keeps `bus_req` low for as long as `older_safe` stays low. `bus_req` rises in the cycle after `older_safe` is seen high.
- R4: A read retires only after its data: `retire` is high for exactly one cycle, the cycle after `bus_data_done` is seen following the address acknowledge.
- R5: A write retires in the cycle after its address acknowledge, without waiting for `bus_data_done`. `retire` is high for one cycle.
- R6: Before the acknowledge, `acc_flush` or `async_irq` makes `cancel` high in that same cycle, while the access is stalled or requesting. In the next cycle `bus_req` is low and `acc_ready` is high, and no `retire` follows.
- R7: After the address acknowledge, `acc_flush` and `async_irq` have no effect: `cancel` stays low and the access still retires.
- R8: When `bus_addr_ack` and a flush or interrupt arrive in the same requesting cycle, the acknowledge wins. No cancel is given and the access completes.
- R9: `acc_ready` is high only when idle. An access presented while busy is dropped and produces no later bus request.
- R10: While `bus_req` is high, `bus_write` is 1 for a store and 0 for a load, as captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_hit | input | 1 | Access hit in the cache (bypasses the gate) |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_guarded | input | 1 | Page carries the guarded attribute |
| older_safe | input | 1 | All older instructions will complete without exception |
| acc_flush | input | 1 | Flush from an exception or mispredicted branch |
| async_irq | input | 1 | Asynchronous interrupt pending |
| bus_addr_ack | input | 1 | Bus accepted the address phase |
| bus_data_done | input | 1 | Bus finished the read data phase |
| acc_ready | output | 1 | Gate idle, can take an access |
| bus_req | output | 1 | Request to the bus |
| bus_write | output | 1 | Direction of the requested access |
| retire | output | 1 | One-cycle pulse: access retired |
| cancel | output | 1 | Pulse: access cancelled before acknowledge |

## Verification
The issue decision is exercised with four patterns:
- A cache hit shows that the bypass never reaches the bus.
- An unguarded miss with unsafe older state shows that the guard is the only reason to stall.
- A guarded miss held for several cycles shows that the stall lasts exactly as long as `older_safe` is low.
- A guarded miss with safe older state shows that an access that is already safe is not delayed.

The completion patterns cover the remaining rules:
- A read compared with a write shows the two retire points.
- Flushes and interrupts before, at and after the acknowledge show where cancellation stops being possible.
- An access presented while busy shows that the single slot is not overwritten.

// File: rtl/gia_pkg.sv
package gia_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_SAFE = 3'd1,
    ST_REQ       = 3'd2,
    ST_ACKED     = 3'd3,
    ST_DONE      = 3'd4
  } gia_state_e;

  // Guarded page with unresolved older work must stall first.
  function automatic logic f_needs_wait(input logic guarded, input logic safe);
    return guarded & ~safe;
  endfunction

  // Any reason to throw away an access not yet acknowledged.
  function automatic logic f_kill(input logic flush, input logic irq);
    return flush | irq;
  endfunction

  // Retire point: reads on leaving DONE, writes on leaving ACKED.
  function automatic logic f_retire_now(input gia_state_e st, input logic is_wr);
    return (st == ST_DONE) || ((st == ST_ACKED) && is_wr);
  endfunction

endpackage

// File: rtl/gia_attr_reg.sv
module gia_attr_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic wr_in,
  output logic wr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wr_q <= 1'b0;
    else if (load) wr_q <= wr_in;
  end
endmodule

// File: rtl/gia_fsm.sv
module gia_fsm
  import gia_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_miss,
  input  logic       guarded_in,
  input  logic       older_safe,
  input  logic       kill,
  input  logic       addr_ack,
  input  logic       data_done,
  input  logic       is_write,
  output gia_state_e state,
  output logic       cancel_ev
);
  gia_state_e nxt;

  always_comb begin
    nxt       = state;
    cancel_ev = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_miss)
          nxt = f_needs_wait(guarded_in, older_safe) ? ST_WAIT_SAFE : ST_REQ;
      end
      ST_WAIT_SAFE: begin
        if (kill) begin
          cancel_ev = 1'b1;
          nxt       = ST_IDLE;
        end else if (older_safe) begin
          nxt = ST_REQ;
        end
      end
      ST_REQ: begin
        if (addr_ack) begin
          nxt = ST_ACKED;
        end else if (kill) begin
          cancel_ev = 1'b1;
          nxt       = ST_IDLE;
        end
      end
      ST_ACKED: begin
        if (is_write)       nxt = ST_IDLE;
        else if (data_done) nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_WAIT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_SAFE && older_safe && !kill) |=> (state == ST_REQ)); // R3
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && addr_ack) |=> (state == ST_ACKED)); // R8
  AST_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACKED || state == ST_DONE) |-> !cancel_ev); // R7
endmodule

// File: rtl/gia_out_dec.sv
module gia_out_dec
  import gia_pkg::*;
(
  input  gia_state_e state,
  input  logic       wr_q,
  output logic       ready,
  output logic       req,
  output logic       req_wr,
  output logic       retire
);
  always_comb begin
    ready  = (state == ST_IDLE);
    req    = (state == ST_REQ);
    req_wr = req & wr_q;
    retire = f_retire_now(state, wr_q);
  end
endmodule

// File: rtl/guard_issue_gate.sv
module guard_issue_gate
  import gia_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic acc_hit,
  input  logic acc_write,
  input  logic acc_guarded,
  input  logic older_safe,
  input  logic acc_flush,
  input  logic async_irq,
  input  logic bus_addr_ack,
  input  logic bus_data_done,
  output logic acc_ready,
  output logic bus_req,
  output logic bus_write,
  output logic retire,
  output logic cancel
);
  gia_state_e state;
  logic       wr_q;
  logic       start_miss;
  logic       kill;
  logic       cancel_ev;

  assign start_miss = acc_valid & ~acc_hit & acc_ready;
  assign kill       = f_kill(acc_flush, async_irq);

  gia_attr_reg u_attr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_miss),
    .wr_in (acc_write),
    .wr_q  (wr_q)
  );

  gia_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_miss (start_miss),
    .guarded_in (acc_guarded),
    .older_safe (older_safe),
    .kill       (kill),
    .addr_ack   (bus_addr_ack),
    .data_done  (bus_data_done),
    .is_write   (wr_q),
    .state      (state),
    .cancel_ev  (cancel_ev)
  );

  gia_out_dec u_dec (
    .state  (state),
    .wr_q   (wr_q),
    .ready  (acc_ready),
    .req    (bus_req),
    .req_wr (bus_write),
    .retire (retire)
  );

  assign cancel = cancel_ev;

  AST_HIT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid && acc_hit) |=> (!bus_req && acc_ready)); // R1
  AST_UNGUARDED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && acc_valid && !acc_hit && !acc_guarded) |=> bus_req); // R2
  AST_GUARD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_SAFE) |-> !bus_req); // R3
  AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire); // R4
  AST_CANCEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!bus_req && acc_ready && !retire)); // R6
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && cancel)); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !(bus_req || retire)); // R9
endmodule

// File: tb/sim_guard_issue_gate.sv
module sim_guard_issue_gate;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_hit = 0, acc_write = 0, acc_guarded = 0;
  logic older_safe = 0, acc_flush = 0, async_irq = 0;
  logic bus_addr_ack = 0, bus_data_done = 0;
  logic acc_ready, bus_req, bus_write, retire, cancel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard item: 1 = retire expected, 0 = cancel expected
  bit exp_q[$];

  always #(CLK_PER/2) clk = ~clk;

  guard_issue_gate u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_write(acc_write), .acc_guarded(acc_guarded), .older_safe(older_safe),
    .acc_flush(acc_flush), .async_irq(async_irq), .bus_addr_ack(bus_addr_ack),
    .bus_data_done(bus_data_done), .acc_ready(acc_ready), .bus_req(bus_req),
    .bus_write(bus_write), .retire(retire), .cancel(cancel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // bench-side restatement of the stall rule
  function automatic bit must_stall(input bit g, input bit s);
    return g && !s;
  endfunction

  task automatic present(input bit wr, input bit gd, input bit hit);
    acc_valid = 1; acc_write = wr; acc_guarded = gd; acc_hit = hit;
    tick();
    acc_valid = 0; acc_hit = 0;
  endtask

  // monitor: pops expected outcomes as retire/cancel pulses appear
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PER/4);
      if (rst_n && (retire || cancel)) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6/R7: unexpected outcome retire=%b cancel=%b expected none", retire, cancel);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (retire !== e || cancel !== !e) begin
            errors++;
            $display("FAIL R4/R6: outcome retire=%b cancel=%b expected retire=%b", retire, cancel, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PER*5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    chk("reset ready", acc_ready, 1);
    chk("reset bus_req", bus_req, 0);
    chk("reset retire", retire, 0);
    chk("reset cancel", cancel, 0);

    // R1 cache hit
    present(0, 1, 1);
    chk("R1 no req", bus_req, 0);
    chk("R1 ready", acc_ready, 1);

    // R2 unguarded read with unsafe older state, R10 direction, R4 retire
    older_safe = 0;
    present(0, 0, 0);
    chk("R2 req", bus_req, 1);
    chk("R10 read dir", bus_write, 0);
    exp_q.push_back(1);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    chk("R4 no early retire", retire, 0);
    tick();
    chk("R4 still waiting for data", retire, 0);
    bus_data_done = 1; tick(); bus_data_done = 0;
    chk("R4 retire after data", retire, 1);
    tick();
    chk("R4 pulse ends", retire, 0);
    chk("R4 idle again", acc_ready, 1);

    // R3 guarded read stalls; R7 flush and irq after ack ignored
    older_safe = 0;
    present(0, 1, 0);
    chk("R3 stall", bus_req, must_stall(1, 0) ? 1'b0 : 1'b1);
    chk("R9 busy", acc_ready, 0);
    // R9 a second access while busy is dropped
    present(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R3 still stalled", bus_req, 0);
      tick();
    end
    older_safe = 1; tick();
    chk("R3 req after safe", bus_req, 1);
    exp_q.push_back(1);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    acc_flush = 1; async_irq = 1; #1;
    chk("R7 no cancel after ack", cancel, 0);
    tick();
    chk("R7 no cancel holding", cancel, 0);
    bus_data_done = 1; tick(); bus_data_done = 0;
    acc_flush = 0; async_irq = 0;
    chk("R7 retires anyway", retire, 1);
    tick();
    chk("R9 dropped access gives no req", bus_req, 0);
    chk("R9 ready", acc_ready, 1);

    // R5 guarded write with safe older state
    older_safe = 1;
    present(1, 1, 0);
    chk("R5 req immediately when safe", bus_req, 1);
    chk("R10 write dir", bus_write, 1);
    exp_q.push_back(1);
    bus_addr_ack = 1; tick(); bus_addr_ack = 0;
    chk("R5 write retires after ack", retire, 1);
    tick();
    chk("R5 pulse ends", retire, 0);

    // R6 flush while stalled
    older_safe = 0;
    present(0, 1, 0);
    exp_q.push_back(0);
    acc_flush = 1; #1;
    chk("R6 cancel while stalled", cancel, 1);
    tick(); acc_flush = 0;
    chk("R6 no req", bus_req, 0);
    chk("R6 ready", acc_ready, 1);
    chk("R6 no retire", retire, 0);

    // R6 interrupt while requesting
    present(1, 0, 0);
    chk("R2 req unguarded write", bus_req, 1);
    exp_q.push_back(0);
    async_irq = 1; #1;
    chk("R6 cancel while requesting", cancel, 1);
    tick(); async_irq = 0;
    chk("R6 req dropped", bus_req, 0);
    tick();
    chk("R6 no retire later", retire, 0);

    // R8 ack and flush together
    present(0, 0, 0);
    exp_q.push_back(1);
    bus_addr_ack = 1; acc_flush = 1; #1;
    chk("R8 no cancel on ack", cancel, 0);
    tick(); bus_addr_ack = 0; acc_flush = 0;
    chk("R8 committed", bus_req, 0);
    bus_data_done = 1; tick(); bus_data_done = 0;
    chk("R8 retires", retire, 1);
    tick(); tick();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4/R6: %0d outcomes missing expected 0", exp_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule